// File: doc/BRIEF.md
# Receive Break Detector and FIFO Write Gate

This block sits between the frame decoder of a serial receiver and the write port of its receive FIFO. Each completed frame arrives as a one-cycle strobe that carries the data byte and a framing-error bit. A frame whose framing-error bit is set and whose data bits are all zero counts as a line break. That frame is still written into the FIFO as a zero byte, and a sticky break flag is raised. All later frames are then held back from the FIFO until the receive line has stayed at mark level for a full bit period and a fresh frame completes.

The flag stays set until one of two things happens. Software can clear it with a two-step handshake: first a read that sees the flag at 1, then a write of 0. The flag is also cleared when the device enters standby. A standby input resets both the flag and the gating. The bit sampler that produces frames and the FIFO itself are outside this block.

Top module: `rxbrk_gate`

## Requirements
- R1: After reset `brk_flag` is 0 and `fifo_we` is 0.
- R2: A frame is a break when `frm_ferr`=1 and every bit of `frm_data` is 0. A break strobe outside standby makes `brk_flag` read 1 one cycle after the strobe.
- R3: A frame that is not gated produces `fifo_we`=1 for exactly one cycle, one cycle after its `frm_done`, with `fifo_wdata` equal to its data. This includes the break frame itself, which is written as 0.
- R4: After a forwarded break frame, later frames produce no FIFO write until the line has returned to mark.
- R5: Return to mark means `rx_line`=1 continuously while MARK_TICKS `bit_tick` pulses are seen (default 2). Any low sample restarts the count. After a return to mark, the next frame is written and normal forwarding resumes.
- R6: A frame with `frm_ferr`=1 and nonzero data is written unchanged. It neither sets the flag nor starts gating.
- R7: `brk_flag` never rises without a break strobe outside standby. Once set, it keeps its value until it is cleared.
- R8: A write with `flag_wdata`=0 clears the flag only if a `flag_rd` taken while the flag read 1 came after the previous write. A write of 1, or a write with no such read before it, leaves the flag set. Any write ends the armed state.
- R9: If a break strobe and a clearing write fall in the same cycle, the flag ends at 1.
- R10: While `standby`=1, the flag and the armed state are cleared and gating is released. Frames are still written, and break frames do not set the flag.
- R11: A break frame that arrives while gated is not written, but it does set the flag.
- R12: `fifo_we` is never 1 unless `frm_done` was 1 in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frm_done | input | 1 | One-cycle strobe: a frame has completed |
| frm_data | input | DATA_W | Data bits of the completed frame |
| frm_ferr | input | 1 | Stop-bit position was sampled as space |
| rx_line | input | 1 | Receive line level |
| bit_tick | input | 1 | One pulse per bit period |
| standby | input | 1 | Standby mode: clears the flag and the gating |
| flag_rd | input | 1 | Software read of the flag |
| flag_wr | input | 1 | Software write of the flag |
| flag_wdata | input | 1 | Value written by software |
| fifo_we | output | 1 | Gated FIFO write strobe |
| fifo_wdata | output | DATA_W | FIFO write data |
| brk_flag | output | 1 | Sticky break flag |

## Verification
The assertions check on every cycle that the flag is set by a break strobe and by nothing else. They also check that it falls only on standby or a zero write, that standby forces it low, and that every FIFO write echoes the frame strobe of the cycle before. The gating sequence cannot be seen from a single cycle of the ports, so only the bench scenarios show it: the break frame forwarded, the frames after it dropped, an interrupted mark, a complete mark, and the first frame after that. The bench scenarios also cover the read-then-write ordering of the clear handshake and the race between a set and a clear.

// File: rtl/rxbrk_pkg.sv
package rxbrk_pkg;

  typedef enum logic [1:0] {
    GATE_PASS  = 2'd0,
    GATE_HOLD  = 2'd1,
    GATE_REARM = 2'd2
  } gate_st_e;

  // A break: stop position seen as space and no data bit set.
  function automatic logic is_break(input logic ferr, input logic any_one);
    return ferr & ~any_one;
  endfunction

endpackage

// File: rtl/rxbrk_rst_sync.sv
module rxbrk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rxbrk_mark_det.sv
module rxbrk_mark_det #(
  parameter int MARK_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic line,
  input  logic tick,
  output logic mark_ok
);
  localparam int CW = $clog2(MARK_TICKS + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(MARK_TICKS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!enable || !line) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (tick && (cnt_q != CNT_TOP)) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign mark_ok = enable && (cnt_q == CNT_TOP);
endmodule

// File: rtl/rxbrk_flag.sv
module rxbrk_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic standby,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wdata_i,
  output logic flag_o
);
  logic flag_q, flag_d;
  logic arm_q, arm_d;

  always_comb begin
    arm_d = arm_q;
    if (standby)                arm_d = 1'b0;
    else if (wr_i)              arm_d = 1'b0;
    else if (rd_i && flag_q)    arm_d = 1'b1;
  end

  always_comb begin
    flag_d = flag_q;
    if (standby)                          flag_d = 1'b0;
    else if (set_i)                       flag_d = 1'b1;
    else if (wr_i && !wdata_i && arm_q)   flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/rxbrk_gate_ctl.sv
module rxbrk_gate_ctl
  import rxbrk_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_done,
  input  logic [DATA_W-1:0] frm_data,
  input  logic              frm_ferr,
  input  logic              standby,
  input  logic              mark_ok,
  output logic              hunt,
  output logic              brk_set,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o
);
  gate_st_e          state_q, state_d;
  logic              we_q, we_d;
  logic [DATA_W-1:0] wd_q;
  logic              wd_en;
  logic              brk;

  always_comb begin
    brk     = is_break(frm_ferr, |frm_data);
    brk_set = frm_done & brk & ~standby;
    state_d = state_q;
    we_d    = 1'b0;
    if (standby) begin
      state_d = GATE_PASS;
      we_d    = frm_done;
    end else if (frm_done) begin
      if (state_q != GATE_HOLD) begin
        we_d    = 1'b1;
        state_d = brk ? GATE_HOLD : GATE_PASS;
      end
    end else if ((state_q == GATE_HOLD) && mark_ok) begin
      state_d = GATE_REARM;
    end
    wd_en = we_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GATE_PASS;
      we_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      we_q    <= we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wd_q <= '0;
    else if (wd_en) wd_q <= frm_data;
  end

  assign hunt    = (state_q == GATE_HOLD);
  assign we_o    = we_q;
  assign wdata_o = wd_q;
endmodule

// File: rtl/rxbrk_gate.sv
module rxbrk_gate #(
  parameter int DATA_W     = 8,
  parameter int MARK_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_done,
  input  logic [DATA_W-1:0] frm_data,
  input  logic              frm_ferr,
  input  logic              rx_line,
  input  logic              bit_tick,
  input  logic              standby,
  input  logic              flag_rd,
  input  logic              flag_wr,
  input  logic              flag_wdata,
  output logic              fifo_we,
  output logic [DATA_W-1:0] fifo_wdata,
  output logic              brk_flag
);
  logic rst_q_n;
  logic hunt;
  logic mark_ok;
  logic brk_set;

  rxbrk_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  rxbrk_mark_det #(.MARK_TICKS(MARK_TICKS)) u_mark (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .enable  (hunt & ~standby),
    .line    (rx_line),
    .tick    (bit_tick),
    .mark_ok (mark_ok)
  );

  rxbrk_gate_ctl #(.DATA_W(DATA_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .frm_done (frm_done),
    .frm_data (frm_data),
    .frm_ferr (frm_ferr),
    .standby  (standby),
    .mark_ok  (mark_ok),
    .hunt     (hunt),
    .brk_set  (brk_set),
    .we_o     (fifo_we),
    .wdata_o  (fifo_wdata)
  );

  rxbrk_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .standby (standby),
    .set_i   (brk_set),
    .rd_i    (flag_rd),
    .wr_i    (flag_wr),
    .wdata_i (flag_wdata),
    .flag_o  (brk_flag)
  );
endmodule

// File: rtl/rxbrk_gate_chk.sv
module rxbrk_gate_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frm_done,
  input logic [DATA_W-1:0] frm_data,
  input logic              frm_ferr,
  input logic              standby,
  input logic              flag_wr,
  input logic              flag_wdata,
  input logic              fifo_we,
  input logic [DATA_W-1:0] fifo_wdata,
  input logic              brk_flag
);
  logic brk_in;
  assign brk_in = frm_done && frm_ferr && (frm_data == '0) && !standby;

  assert_flag_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    brk_in |=> brk_flag);

  assert_no_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!brk_flag && !brk_in) |=> !brk_flag);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_flag && !standby && !(flag_wr && !flag_wdata)) |=> brk_flag);

  assert_standby_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> !brk_flag);

  assert_write_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_we |-> $past(frm_done));

  assert_write_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_we |-> (fifo_wdata == $past(frm_data)));
endmodule

bind rxbrk_gate rxbrk_gate_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .frm_done   (frm_done),
  .frm_data   (frm_data),
  .frm_ferr   (frm_ferr),
  .standby    (standby),
  .flag_wr    (flag_wr),
  .flag_wdata (flag_wdata),
  .fifo_we    (fifo_we),
  .fifo_wdata (fifo_wdata),
  .brk_flag   (brk_flag)
);

// File: tb/tb_rxbrk_gate.sv
module tb_rxbrk_gate;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frm_done = 1'b0;
  logic [DW-1:0] frm_data = '0;
  logic          frm_ferr = 1'b0;
  logic          rx_line = 1'b1;
  logic          bit_tick = 1'b0;
  logic          standby = 1'b0;
  logic          flag_rd = 1'b0;
  logic          flag_wr = 1'b0;
  logic          flag_wdata = 1'b0;
  logic          fifo_we;
  logic [DW-1:0] fifo_wdata;
  logic          brk_flag;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  rxbrk_gate #(.DATA_W(DW), .MARK_TICKS(2)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one frame; check write strobe, data and flag one cycle later.
  task automatic frame(input logic [DW-1:0] d, input logic fe, input logic exp_we,
                       input logic exp_flag, input string req);
    @(negedge clk);
    frm_done = 1'b1; frm_data = d; frm_ferr = fe;
    @(negedge clk);
    frm_done = 1'b0; frm_ferr = 1'b0;
    chk(req, fifo_we, exp_we);
    if (exp_we) chk(req, fifo_wdata, d);
    chk(req, brk_flag, exp_flag);
  endtask

  task automatic ticks(input int n, input logic lvl);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rx_line = lvl; bit_tick = 1'b1;
      @(negedge clk); bit_tick = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic sw_rd();
    @(negedge clk); flag_rd = 1'b1;
    @(negedge clk); flag_rd = 1'b0;
  endtask

  task automatic sw_wr(input logic v, input logic exp_flag, input string req);
    @(negedge clk); flag_wr = 1'b1; flag_wdata = v;
    @(negedge clk); flag_wr = 1'b0;
    chk(req, brk_flag, exp_flag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 flag", brk_flag, 0);
    chk("R1 we", fifo_we, 0);

    // R3: clean frames, every data value
    for (int v = 0; v < 256; v++) frame(DW'(v), 1'b0, 1'b1, 1'b0, "R3 sweep");
    // R6: framing error with nonzero data
    for (int v = 1; v < 256; v++) frame(DW'(v), 1'b1, 1'b1, 1'b0, "R6 sweep");

    // R2/R3: break frame forwarded as zero, flag set
    rx_line = 1'b0;
    frame('0, 1'b1, 1'b1, 1'b1, "R2 break fwd");
    // R4: frames gated while line low
    frame(8'h5A, 1'b0, 1'b0, 1'b1, "R4 gated");
    frame(8'hA5, 1'b1, 1'b0, 1'b1, "R4 gated ferr");
    // R5: partial mark (one tick) then broken by low
    ticks(1, 1'b1);
    frame(8'h33, 1'b0, 1'b0, 1'b1, "R5 one tick");
    ticks(1, 1'b0);
    ticks(1, 1'b1);
    frame(8'h34, 1'b0, 1'b0, 1'b1, "R5 interrupted");
    // R5: full mark, next frames forwarded
    ticks(2, 1'b1);
    frame(8'h77, 1'b0, 1'b1, 1'b1, "R5 resume");
    frame(8'h78, 1'b0, 1'b1, 1'b1, "R5 after resume");

    // R8: write 0 without read leaves flag
    sw_wr(1'b0, 1'b1, "R8 no read");
    // R8: read then write 1 leaves flag, and disarms
    sw_rd();
    sw_wr(1'b1, 1'b1, "R8 write one");
    sw_wr(1'b0, 1'b1, "R8 disarmed");
    // R8: read then write 0 clears
    sw_rd();
    sw_wr(1'b0, 1'b0, "R8 clear");
    // R8: read while flag 0 does not arm
    sw_rd();
    frame(8'h11, 1'b1, 1'b1, 1'b0, "R6 no flag");
    frame('0, 1'b1, 1'b1, 1'b1, "R2 second break");
    sw_wr(1'b0, 1'b1, "R8 stale read");

    // R11: gated break frame sets flag after a clear
    sw_rd();
    sw_wr(1'b0, 1'b0, "R11 pre clear");
    frame('0, 1'b1, 1'b0, 1'b1, "R11 gated break");

    // R9: clear and set in the same cycle
    sw_rd();
    @(negedge clk);
    flag_wr = 1'b1; flag_wdata = 1'b0;
    frm_done = 1'b1; frm_data = '0; frm_ferr = 1'b1;
    @(negedge clk);
    flag_wr = 1'b0; frm_done = 1'b0; frm_ferr = 1'b0;
    chk("R9 set wins", brk_flag, 1);

    // R10: standby clears flag and gating; break ignored during standby
    @(negedge clk); standby = 1'b1;
    @(negedge clk);
    chk("R10 flag", brk_flag, 0);
    frame('0, 1'b1, 1'b1, 1'b0, "R10 break in standby");
    @(negedge clk); standby = 1'b0;
    frame(8'h42, 1'b0, 1'b1, 1'b0, "R10 released");
    @(negedge clk);
    chk("R12 idle", fifo_we, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule